// File: doc/BRIEF.md
# Nibble-Granular Instruction Prefetch Buffer

This block sits between a byte-wide instruction memory and the decoder of a variable-length instruction set whose instructions are one to four 4-bit nibbles long. It keeps up to eight nibbles, which is enough for up to four short instructions. It decodes the length of the instruction that starts at its head nibble and tells the decoder whether that whole instruction is present. It then presents the instruction left-aligned on a 16-bit output.

Bytes come in on a valid/ready stream. The buffer drives the byte address it wants next and accepts a byte only while it lacks a complete instruction. Instructions leave on a second valid/ready stream. When the decoder takes an instruction, its nibbles are removed and the remaining nibbles move up to the head. A flush input empties the buffer and restarts fetching at any nibble address. For an odd target, the first half of the first byte is dropped.

Back-pressure rules: the producer of bytes must hold `fill_data_i` steady while `fill_valid_i` is high and `fill_ready_o` is low. The byte it offers must be the one at `fetch_addr_o`. The decoder may hold `insn_ready_i` high at any time. A transfer happens only in a cycle where valid and ready are both high, and never in a cycle where `flush_i` is high.

Top module: `nib_prefetch_buffer`

## Requirements
- R1: After reset the buffer is empty: `insn_valid_o` is 0, `fill_ready_o` is 1 and `fetch_addr_o` is 0.
- R2: The instruction length is decoded from the head nibble. Opcodes 0x0 and 0x1 (no-op and return) are 1 nibble long. Opcodes 0x2 to 0x8 are 2 nibbles long. Opcodes 0x9 to 0xE are 3 nibbles long. Opcode 0xF (conditional jump) is 4 nibbles long. The decoded length is shown on `insn_len_o` whenever `insn_valid_o` is 1.
- R3: `insn_valid_o` is 1 exactly when the number of buffered nibbles is at least the decoded length of the head nibble, and no flush is being applied.
- R4: The head instruction is left-aligned on `insn_data_o`. Its first nibble is on bits [15:12], the second on [11:8], the third on [7:4] and the fourth on [3:0]. Bits past the instruction's length carry no meaning.
- R5: `fill_ready_o` is 1 only when no complete instruction is present, no flush is applied and at least two nibble slots are free. The buffered nibble count never exceeds eight.
- R6: Each accepted byte is appended behind the buffered nibbles, high nibble [7:4] first and then low nibble [3:0]. `fetch_addr_o` then advances by one.
- R7: A consume (`insn_valid_o` and `insn_ready_i` both 1) removes exactly the head instruction's nibbles, and the remaining nibbles move up to the head in order. `insn_ready_i` has no effect while `insn_valid_o` is 0.
- R8: A cycle with `flush_i` high empties the buffer and loads `fetch_addr_o` with the target nibble address divided by two. During that cycle both `insn_valid_o` and `fill_ready_o` are 0, so offered bytes and consumes are ignored.
- R9: After a flush to an odd nibble address, only the low nibble of the first accepted byte enters the buffer.
- R10: While no byte is accepted and no flush is applied, `fetch_addr_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the buffer and redirect fetching |
| flush_nib_addr_i | input | ADDR_W+1 | Redirect target as a nibble address |
| fill_valid_i | input | 1 | Instruction byte offered |
| fill_ready_o | output | 1 | Buffer accepts the offered byte |
| fill_data_i | input | 8 | Instruction byte; the high nibble comes first in program order |
| fetch_addr_o | output | ADDR_W | Byte address of the next byte wanted |
| insn_valid_o | output | 1 | A complete instruction is at the head |
| insn_ready_i | input | 1 | Decoder consumes the head instruction |
| insn_len_o | output | 3 | Length in nibbles of the head instruction |
| insn_data_o | output | 16 | Head instruction, left-aligned |

## Verification
The assertions assume that the byte stream obeys the handshake and always offers the byte at `fetch_addr_o`. They also assume that the decoder only counts a consume when it sees valid high, and that a flush lasts a single cycle without needing any transfer to complete. The bench models instruction memory as a fixed function of the byte address. It always drives the byte that the model itself predicts for the current fetch address, and it drives flushes only as one-cycle pulses. The stimulus mixes gaps in byte delivery, stalls by the decoder, a run of redirects over every nibble address in a small window (both parities), and a region laid out so that every opcode value reaches the head.

// File: rtl/nibpf_pkg.sv
package nibpf_pkg;

  typedef logic [3:0] nib_t;

  localparam int MAX_INSN_NIBS = 4;
  localparam int LEN_W         = 3;

  // length in nibbles of the instruction opened by a given opcode nibble
  function automatic logic [LEN_W-1:0] opcode_len(input nib_t op);
    logic [LEN_W-1:0] len;
    if (op <= 4'h1)      len = 3'd1;
    else if (op <= 4'h8) len = 3'd2;
    else if (op <= 4'hE) len = 3'd3;
    else                 len = 3'd4;
    return len;
  endfunction

endpackage

// File: rtl/nibpf_len_decode.sv
module nibpf_len_decode
  import nibpf_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  nib_t             head_nib_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [LEN_W-1:0] len_o,
  output logic             complete_o
);

  always_comb begin
    len_o      = opcode_len(head_nib_i);
    complete_o = (count_i >= CNT_W'(len_o));
  end

endmodule

// File: rtl/nibpf_store.sv
module nibpf_store
  import nibpf_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int WIN_W = 16,
  localparam int VEC_W = 4 * SLOTS,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             pop_i,
  input  logic [LEN_W-1:0] pop_len_i,
  input  logic             push_i,
  input  logic             push_two_i,
  input  logic [7:0]       push_byte_i,
  output logic [WIN_W-1:0] head_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] free_o
);

  logic [VEC_W-1:0] q_r, shifted, app, q_nx;
  logic [CNT_W-1:0] cnt_r, sh, rem, addn, cnt_nx;

  // shift out the consumed nibbles, then append behind what remains
  always_comb begin
    sh      = pop_i ? CNT_W'(pop_len_i) : '0;
    shifted = q_r << {sh, 2'b00};
    rem     = cnt_r - sh;
    app     = '0;
    addn    = '0;
    if (push_i) begin
      if (push_two_i) begin
        app  = {push_byte_i, {(VEC_W-8){1'b0}}} >> {rem, 2'b00};
        addn = CNT_W'(2);
      end else begin
        app  = {push_byte_i[3:0], {(VEC_W-4){1'b0}}} >> {rem, 2'b00};
        addn = CNT_W'(1);
      end
    end
    q_nx   = shifted | app;
    cnt_nx = rem + addn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      cnt_r <= '0;
    end else if (flush_i) begin
      q_r   <= '0;
      cnt_r <= '0;
    end else begin
      q_r   <= q_nx;
      cnt_r <= cnt_nx;
    end
  end

  assign head_o  = q_r[VEC_W-1 -: WIN_W];
  assign count_o = cnt_r;
  assign free_o  = CNT_W'(SLOTS) - cnt_r;

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_r <= CNT_W'(SLOTS));

  p_push_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (free_o >= CNT_W'(2)));

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cnt_r == '0));

  p_pop_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (cnt_r >= CNT_W'(pop_len_i)));

  p_pop_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !flush_i) |=> (cnt_r == $past(cnt_r) - CNT_W'($past(pop_len_i))));

  p_push_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !flush_i) |=>
      (cnt_r == $past(cnt_r) + ($past(push_two_i) ? CNT_W'(2) : CNT_W'(1))));

endmodule

// File: rtl/nibpf_fetch_ctrl.sv
module nibpf_fetch_ctrl #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W:0]   flush_nib_addr_i,
  input  logic              fill_hs_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              skip_hi_o
);

  logic [ADDR_W-1:0] addr_r;
  logic              skip_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_r <= '0;
      skip_r <= 1'b0;
    end else if (flush_i) begin
      addr_r <= flush_nib_addr_i[ADDR_W:1];
      skip_r <= flush_nib_addr_i[0];
    end else if (fill_hs_i) begin
      addr_r <= addr_r + 1'b1;
      skip_r <= 1'b0;
    end
  end

  assign fetch_addr_o = addr_r;
  assign skip_hi_o    = skip_r;

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_hs_i && !flush_i) |=> (addr_r == $past(addr_r) + 1'b1));

  p_flush_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (addr_r == $past(flush_nib_addr_i[ADDR_W:1])));

  p_skip_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && flush_nib_addr_i[0]) |=> skip_r);

  p_skip_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_hs_i && !flush_i) |=> !skip_r);

endmodule

// File: rtl/nib_prefetch_buffer.sv
module nib_prefetch_buffer
  import nibpf_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SLOTS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W:0]   flush_nib_addr_i,
  input  logic              fill_valid_i,
  output logic              fill_ready_o,
  input  logic [7:0]        fill_data_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              insn_valid_o,
  input  logic              insn_ready_i,
  output logic [2:0]        insn_len_o,
  output logic [15:0]       insn_data_o
);

  localparam int WIN_W = 4 * MAX_INSN_NIBS;
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [WIN_W-1:0] head;
  logic [CNT_W-1:0] count, free;
  logic [LEN_W-1:0] len;
  logic             complete, skip_hi, fill_hs, pop;

  nibpf_len_decode #(.CNT_W(CNT_W)) len_dec_i (
    .head_nib_i (head[WIN_W-1 -: 4]),
    .count_i    (count),
    .len_o      (len),
    .complete_o (complete)
  );

  assign insn_valid_o = complete && !flush_i;
  assign fill_ready_o = !complete && !flush_i && (free >= CNT_W'(2));
  assign fill_hs      = fill_valid_i && fill_ready_o;
  assign pop          = insn_valid_o && insn_ready_i;
  assign insn_len_o   = len;
  assign insn_data_o  = head;

  nibpf_store #(.SLOTS(SLOTS), .WIN_W(WIN_W)) store_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .pop_i       (pop),
    .pop_len_i   (len),
    .push_i      (fill_hs),
    .push_two_i  (!skip_hi),
    .push_byte_i (fill_data_i),
    .head_o      (head),
    .count_o     (count),
    .free_o      (free)
  );

  nibpf_fetch_ctrl #(.ADDR_W(ADDR_W)) fetch_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .flush_i          (flush_i),
    .flush_nib_addr_i (flush_nib_addr_i),
    .fill_hs_i        (fill_hs),
    .fetch_addr_o     (fetch_addr_o),
    .skip_hi_o        (skip_hi)
  );

  p_hold_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_hs && !flush_i) |=> $stable(fetch_addr_o));

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(insn_valid_o && fill_ready_o));

  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> (!insn_valid_o && !fill_ready_o));

endmodule

// File: tb/nib_prefetch_buffer_tb_top.sv
module nib_prefetch_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush_i = 1'b0;
  logic [ADDR_W:0]   flush_nib_addr_i = '0;
  logic              fill_valid_i = 1'b0;
  logic              fill_ready_o;
  logic [7:0]        fill_data_i = '0;
  logic [ADDR_W-1:0] fetch_addr_o;
  logic              insn_valid_o;
  logic              insn_ready_i = 1'b0;
  logic [2:0]        insn_len_o;
  logic [15:0]       insn_data_o;

  int checks = 0;
  int bad    = 0;
  int ptr    = 0;   // model: nibble address of head
  int cnt    = 0;   // model: buffered nibbles
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  nib_prefetch_buffer #(.ADDR_W(ADDR_W), .SLOTS(8)) dut_i (
    .clk, .rst_n, .flush_i, .flush_nib_addr_i, .fill_valid_i, .fill_ready_o,
    .fill_data_i, .fetch_addr_o, .insn_valid_o, .insn_ready_i, .insn_len_o,
    .insn_data_o
  );

  // bytes 0..15 hold {k, 0} so every opcode can be placed at the head
  function automatic logic [7:0] mem_byte(input int a);
    int h;
    if (a < 16) return {a[3:0], 4'h0};
    h = a * 73 + (a >> 2) * 29 + 5;
    return h[7:0];
  endfunction

  function automatic logic [3:0] nib_at(input int p);
    logic [7:0] b;
    b = mem_byte(p >> 1);
    return p[0] ? b[3:0] : b[7:4];
  endfunction

  function automatic int len_of(input logic [3:0] op);
    if (op <= 4'h1) return 1;
    if (op <= 4'h8) return 2;
    if (op <= 4'hE) return 3;
    return 4;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit fl, input int tgt, input bit fv, input bit rdy);
    bit expv, expfr;
    int L, ef;
    logic [15:0] mask, expd;
    @(negedge clk);
    flush_i = 1'b0; fill_valid_i = 1'b0; insn_ready_i = 1'b0;
    #1;
    L     = len_of(nib_at(ptr));
    expv  = (cnt > 0) && (cnt >= L);
    expfr = !expv && (cnt <= 6);
    chk(insn_valid_o == expv, "R3 insn_valid", int'(insn_valid_o), int'(expv));
    chk(fill_ready_o == expfr, "R5 fill_ready", int'(fill_ready_o), int'(expfr));
    ef = ((ptr + cnt) >> 1) % (1 << ADDR_W);
    chk(int'(fetch_addr_o) == ef, "R6/R10 fetch_addr", int'(fetch_addr_o), ef);
    if (expv) begin
      chk(int'(insn_len_o) == L, "R2 insn_len", int'(insn_len_o), L);
      mask = '0; expd = '0;
      for (int k = 0; k < L; k++) begin
        mask[15-4*k -: 4] = 4'hF;
        expd[15-4*k -: 4] = nib_at(ptr + k);
      end
      chk((insn_data_o & mask) == expd, "R4/R7 insn_data", int'(insn_data_o & mask), int'(expd));
    end
    if (fl) begin
      flush_i = 1'b1;
      flush_nib_addr_i = tgt[ADDR_W:0];
      fill_valid_i = fv;
      fill_data_i = mem_byte(ef);
      insn_ready_i = rdy;
      #1;
      chk(!insn_valid_o && !fill_ready_o, "R8 quiet during flush",
          int'({insn_valid_o, fill_ready_o}), 0);
      ptr = tgt;
      cnt = 0;
    end else begin
      fill_valid_i = fv;
      fill_data_i = mem_byte(ef);
      insn_ready_i = rdy;
      if (expv && rdy) begin
        ptr += L;
        cnt -= L;
      end
      if (fv && expfr) cnt += ((ptr + cnt) % 2 == 1) ? 1 : 2;  // R9 odd start adds one
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(insn_valid_o == 1'b0, "R1 reset valid", int'(insn_valid_o), 0);
    chk(fill_ready_o == 1'b1, "R1 reset fill_ready", int'(fill_ready_o), 1);
    chk(fetch_addr_o == '0, "R1 reset fetch_addr", int'(fetch_addr_o), 0);
    rst_n = 1'b1;

    // R2: each opcode brought to the head, decoder stalled
    for (int op = 0; op < 16; op++) begin
      step(1'b1, 2 * op, 1'b1, 1'b1);
      for (int i = 0; i < 5; i++) step(1'b0, 0, 1'b1, 1'b0);
    end

    // R9: odd redirect, then R10: bytes withheld
    step(1'b1, 41, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b0, 0, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) step(1'b0, 0, 1'b1, 1'b1);

    // mixed traffic with a redirect sweep over nibble addresses 0..127
    begin
      int sweep = 0;
      for (int i = 0; i < 8000; i++) begin
        bit fl, fv, rdy;
        seed = seed * 32'd1103515245 + 32'd12345;
        fl  = (seed[21:16] == 6'd0);
        fv  = seed[24] | seed[25];
        rdy = seed[27] | seed[28];
        step(fl, sweep % 128 + ((sweep / 128) % 2) * 128, fv, rdy);
        if (fl) sweep++;
      end
    end

    step(1'b0, 0, 1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule